// File: doc/BRIEF.md
# Four-Port Serial Management Slave with Interrupt Slot

This block answers serial management frames for four PHY ports that share one clock/data pair. The host sends frames on MDC and MDIO. Each frame carries a preamble of ones, a start pattern, an opcode, a 5-bit port address, a 5-bit register address, a turnaround and 16 data bits, most significant bit first. The block runs on a fast system clock and detects MDC edges by oversampling. It samples MDIO on each rising MDC edge and changes its own drive just after each falling edge. It drives MDIO through a value/enable pair that feeds an external open-drain pad.

A port answers to the address whose upper three bits equal the `devsel` inputs and whose lower two bits equal the port index. Each port has three registers:

- a 16-bit control word, readable and writable, also brought out on `ctl_regs`;
- a status word whose bit 0 holds a sticky pending-interrupt flag;
- an interrupt-enable bit.

Every accepted transfer is followed by a quiescent bit that nobody drives. One more bit slot then follows. If any port has both its pending flag and its enable set, the block pulls MDIO low during the high phase of MDC in that slot. It lets go at the next falling edge.

The parser states are:

- IDLE: counts preamble ones.
- START: expects the second start bit.
- OPC: reads the opcode.
- PHY: reads the port address.
- REG: reads the register address.
- TURN: the turnaround.
- DATA: the 16 data bits.
- QUIET: the quiescent bit.
- IRQ: the interrupt slot.

The transitions, each taken on a rising MDC edge, are:

- IDLE→START: a 0 after at least 32 ones.
- START→OPC: a 1. START→IDLE: a 0.
- OPC→PHY: a valid opcode. OPC→IDLE: an invalid one.
- PHY→REG: after 5 bits.
- REG→TURN: the address matches. REG→IDLE: it does not.
- TURN→DATA: after 2 bits.
- DATA→QUIET: after 16 bits.
- QUIET→IRQ: after one bit.
- IRQ→IDLE: after one bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, `mdio_oe` is 0, every control word is 0, and every pending flag and enable bit is 0.
- R2: A port is selected when address bits [4:2] equal `devsel` and bits [1:0] equal its index (0 to 3). A write changes only that port's control word, which appears on `ctl_regs[16*i +: 16]`.
- R3: A frame is accepted only if at least 32 consecutive ones precede the start pattern 0 then 1. With 31 ones, the frame is ignored: there is no drive and no write.
- R4: A write frame (opcode 01) with register address 0 stores the 16 data bits, sampled MSB first on rising MDC, into the addressed control word.
- R5: In a read frame (opcode 10), the block leaves MDIO undriven for the first turnaround bit. It drives 0 for the second turnaround bit and then the 16 register bits MSB first, each valid at the rising MDC edge.
- R6: A frame whose address bits [4:2] differ from `devsel` is ignored: MDIO is never driven and no register changes.
- R7: During the quiescent bit after an accepted transfer, `mdio_oe` is 0.
- R8: In the bit slot after the quiescent bit, if some port has both its pending flag and its enable set, MDIO is driven low while MDC is high. It is released at the next falling MDC edge.
- R9: If no port has both its pending flag and its enable set, MDIO is not driven in the interrupt slot. A pending flag whose enable is 0 does not count.
- R10: Register address 1 reads the pending flag in bit 0, with all other bits 0. Reading it clears that port's flag, and `irq_req[i]` high sets the flag again. Register address 2 holds the enable in bit 0 (read/write). Other addresses read 0 and ignore writes.
- R11: A frame with opcode 00 or 11 is ignored: there is no drive and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Active-low reset |
| mdc | input | 1 | Management clock from the host |
| mdio_in | input | 1 | Level seen on the management data line |
| devsel | input | 3 | Upper three address bits shared by all ports |
| irq_req | input | 4 | Per-port request that sets the sticky pending flag |
| mdio_out | output | 1 | Value driven on the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| ctl_regs | output | 64 | Control words, port i in bits 16*i+15 to 16*i |

## Verification
Directed frames cover several cases:

- writes with distinct data to all four ports, followed by read-back, which separates the port decode from the data path;
- frames with a foreign device select, a 31-one preamble and invalid opcodes, where the absence of any drive shows that the frame was dropped rather than half-decoded;
- an exactly 32-one preamble, which marks the acceptance boundary;
- an interrupt sequence (request with the enable off, then enable on, then a status read), which separates a raw pending flag from an enabled one and shows the clear on read.

Seeded random frames then mix ports, opcodes, registers, data and request pulses. These catch ordering faults between register updates and the interrupt slot.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TURN,
        ST_DATA,
        ST_QUIET,
        ST_IRQ
    } mdio_st_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_edge_det.sv
module mdio_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    output logic rise,
    output logic fall
);
    logic mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc;
    end

    assign rise = mdc & ~mdc_q;
    assign fall = ~mdc & mdc_q;
endmodule

// File: rtl/mdio_port_bank.sv
module mdio_port_bank #(
    parameter int DW      = 16,
    parameter int RAW     = 5,
    parameter int CTL_ADR = 0,
    parameter int STS_ADR = 1,
    parameter int IEN_ADR = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_reg,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_hit,
    input  logic [RAW-1:0] rd_reg,
    input  logic           irq_req,
    output logic [DW-1:0]  rd_data,
    output logic [DW-1:0]  ctl,
    output logic           irq_live
);
    logic ien;
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl  <= '0;
            ien  <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (wr_en && wr_reg == RAW'(CTL_ADR)) ctl <= wr_data;
            if (wr_en && wr_reg == RAW'(IEN_ADR)) ien <= wr_data[0];
            if (irq_req)
                pend <= 1'b1;
            else if (rd_hit && rd_reg == RAW'(STS_ADR))
                pend <= 1'b0;
        end
    end

    always_comb begin
        if (rd_reg == RAW'(CTL_ADR))      rd_data = ctl;
        else if (rd_reg == RAW'(STS_ADR)) rd_data = {{(DW-1){1'b0}}, pend};
        else if (rd_reg == RAW'(IEN_ADR)) rd_data = {{(DW-1){1'b0}}, ien};
        else                              rd_data = '0;
    end

    assign irq_live = pend & ien;
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slv_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 5,
    parameter int PORT_AW = 2,
    parameter int PRE_MIN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  bit_in,
    input  logic [AW-PORT_AW-1:0] devsel,
    input  logic [DW-1:0]         rd_data,
    input  logic                  irq_any,
    output mdio_st_e              st,
    output logic                  rd_stb,
    output logic [PORT_AW-1:0]    rd_port,
    output logic [AW-1:0]         rd_reg,
    output logic                  wr_stb,
    output logic [PORT_AW-1:0]    wr_port,
    output logic [AW-1:0]         wr_reg,
    output logic [DW-1:0]         wr_data,
    output logic                  mdio_out,
    output logic                  mdio_oe
);
    localparam int CW = $clog2(DW) + 1;
    localparam int OW = $clog2(PRE_MIN + 1);
    localparam logic [CW-1:0] LAST_ADR  = CW'(AW - 1);
    localparam logic [CW-1:0] LAST_DAT  = CW'(DW - 1);
    localparam logic [CW-1:0] LAST_PAIR = CW'(1);

    mdio_st_e          state, nxt;
    logic [OW-1:0]     ones;
    logic [CW-1:0]     bcnt;
    logic              opc_first;
    logic              is_rd;
    logic [AW-1:0]     phy_sh;
    logic [AW-2:0]     reg_sh;
    logic [DW-1:0]     wsh;
    logic [DW-1:0]     rsh;
    logic [AW-1:0]     reg_full;
    logic              hit;
    logic              op_ok;

    assign reg_full = {reg_sh, bit_in};
    assign hit      = (phy_sh[AW-1:PORT_AW] == devsel);
    assign op_ok    = ({opc_first, bit_in} == OP_RD) || ({opc_first, bit_in} == OP_WR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state, evaluated on rising MDC only
    always_comb begin
        nxt = state;
        if (rise) begin
            unique case (state)
                ST_IDLE:  if (!bit_in && ones >= OW'(PRE_MIN)) nxt = ST_START;
                ST_START: nxt = bit_in ? ST_OPC : ST_IDLE;
                ST_OPC:   if (bcnt == LAST_PAIR) nxt = op_ok ? ST_PHY : ST_IDLE;
                ST_PHY:   if (bcnt == LAST_ADR) nxt = ST_REG;
                ST_REG:   if (bcnt == LAST_ADR) nxt = hit ? ST_TURN : ST_IDLE;
                ST_TURN:  if (bcnt == LAST_PAIR) nxt = ST_DATA;
                ST_DATA:  if (bcnt == LAST_DAT) nxt = ST_QUIET;
                ST_QUIET: nxt = ST_IRQ;
                ST_IRQ:   nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    assign rd_stb  = rise && state == ST_REG && bcnt == LAST_ADR && hit && is_rd;
    assign rd_port = phy_sh[PORT_AW-1:0];
    assign rd_reg  = reg_full;
    assign wr_data = wsh;
    assign st      = state;

    // datapath and line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones      <= '0;
            bcnt      <= '0;
            opc_first <= 1'b0;
            is_rd     <= 1'b0;
            phy_sh    <= '0;
            reg_sh    <= '0;
            wsh       <= '0;
            rsh       <= '0;
            wr_stb    <= 1'b0;
            wr_port   <= '0;
            wr_reg    <= '0;
            mdio_out  <= 1'b0;
            mdio_oe   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (rise) begin
                if (state == ST_IDLE && bit_in)
                    ones <= (ones >= OW'(PRE_MIN)) ? ones : ones + 1'b1;
                else
                    ones <= '0;
                bcnt <= (nxt != state) ? '0 : bcnt + 1'b1;
                unique case (state)
                    ST_OPC: begin
                        opc_first <= bit_in;
                        if (bcnt == LAST_PAIR) is_rd <= ({opc_first, bit_in} == OP_RD);
                    end
                    ST_PHY: phy_sh <= {phy_sh[AW-2:0], bit_in};
                    ST_REG: begin
                        reg_sh <= reg_full[AW-2:0];
                        if (bcnt == LAST_ADR) begin
                            wr_port <= phy_sh[PORT_AW-1:0];
                            wr_reg  <= reg_full;
                            if (is_rd) rsh <= rd_data;
                        end
                    end
                    ST_DATA: begin
                        wsh <= {wsh[DW-2:0], bit_in};
                        if (bcnt == LAST_DAT && !is_rd) wr_stb <= 1'b1;
                    end
                    ST_IRQ: begin
                        if (irq_any) begin
                            mdio_oe  <= 1'b1;
                            mdio_out <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else if (fall) begin
                if (state == ST_TURN && bcnt == LAST_PAIR && is_rd) begin
                    mdio_oe  <= 1'b1;
                    mdio_out <= 1'b0;
                end else if (state == ST_DATA && is_rd) begin
                    mdio_oe  <= 1'b1;
                    mdio_out <= rsh[DW-1];
                    rsh      <= {rsh[DW-2:0], 1'b0};
                end else begin
                    mdio_oe  <= 1'b0;
                    mdio_out <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_slv_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int DW      = 16,
    parameter int AW      = 5,
    parameter int PRE_MIN = 32,
    parameter int CTL_ADR = 0,
    parameter int STS_ADR = 1,
    parameter int IEN_ADR = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            mdc,
    input  logic                            mdio_in,
    input  logic [AW-$clog2(NPORT)-1:0]     devsel,
    input  logic [NPORT-1:0]                irq_req,
    output logic                            mdio_out,
    output logic                            mdio_oe,
    output logic [NPORT*DW-1:0]             ctl_regs
);
    localparam int PORT_AW = $clog2(NPORT);

    logic                rise, fall;
    mdio_st_e            st;
    logic                rd_stb, wr_stb;
    logic [PORT_AW-1:0]  rd_port, wr_port;
    logic [AW-1:0]       rd_reg, wr_reg;
    logic [DW-1:0]       wr_data, rd_data;
    logic                irq_any;
    logic [DW-1:0]       bank_rd [NPORT];
    logic [NPORT-1:0]    irq_live;

    mdio_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_fsm #(
        .DW(DW), .AW(AW), .PORT_AW(PORT_AW), .PRE_MIN(PRE_MIN)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .fall    (fall),
        .bit_in  (mdio_in),
        .devsel  (devsel),
        .rd_data (rd_data),
        .irq_any (irq_any),
        .st      (st),
        .rd_stb  (rd_stb),
        .rd_port (rd_port),
        .rd_reg  (rd_reg),
        .wr_stb  (wr_stb),
        .wr_port (wr_port),
        .wr_reg  (wr_reg),
        .wr_data (wr_data),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic [DW-1:0] ctl_w;
        mdio_port_bank #(
            .DW(DW), .RAW(AW), .CTL_ADR(CTL_ADR), .STS_ADR(STS_ADR), .IEN_ADR(IEN_ADR)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stb && wr_port == PORT_AW'(i)),
            .wr_reg  (wr_reg),
            .wr_data (wr_data),
            .rd_hit  (rd_stb && rd_port == PORT_AW'(i)),
            .rd_reg  (rd_reg),
            .irq_req (irq_req[i]),
            .rd_data (bank_rd[i]),
            .ctl     (ctl_w),
            .irq_live(irq_live[i])
        );
        assign ctl_regs[i*DW +: DW] = ctl_w;
    end

    assign rd_data = bank_rd[rd_port];
    assign irq_any = |irq_live;
endmodule

// File: rtl/mdio_slv_chk.sv
module mdio_slv_chk
    import mdio_slv_pkg::*;
#(
    parameter int CW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mdc,
    input logic          mdio_oe,
    input logic          mdio_out,
    input mdio_st_e      st,
    input logic          irq_any,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic [CW-1:0] ctl_regs
);
    // R5
    turn_drives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TURN && mdio_oe) |-> !mdio_out);

    // R6
    no_drive_in_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START || st == ST_OPC || st == ST_PHY || st == ST_REG) |-> !mdio_oe);

    // R8
    irq_release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && st == ST_IDLE && !mdc) |=> !mdio_oe);

    // R9
    irq_needs_enabled_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $rose(mdio_oe)) |-> $past(irq_any));

    // R8
    irq_drive_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && mdio_oe) |-> !mdio_out);

    // R4
    ctl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(ctl_regs));

    // R10
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
endmodule

bind mdio_mgmt_slave mdio_slv_chk #(.CW(NPORT*DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .mdio_out(mdio_out),
    .st      (st),
    .irq_any (irq_any),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .ctl_regs(ctl_regs)
);

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic [2:0]  devsel = 3'b101;
    logic [3:0]  irq_req = 4'b0;
    logic        host_en = 1'b0;
    logic        host_val = 1'b1;
    wire         mdio_out;
    wire         mdio_oe;
    wire [63:0]  ctl_regs;
    wire         mdio_line = mdio_oe ? mdio_out : (host_en ? host_val : 1'b1);

    always #4 clk = ~clk;

    mdio_mgmt_slave i_mdio_mgmt_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_line),
        .devsel  (devsel),
        .irq_req (irq_req),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe),
        .ctl_regs(ctl_regs)
    );

    int total = 0;
    int bad = 0;

    logic [15:0] m_ctl [4];
    logic        m_en  [4];
    logic        m_pend[4];

    logic        r_ta1_oe, r_ta2_line, r_ta2_oe, r_quiet_oe, r_slot_line, r_rel_oe, r_any_oe;
    logic [15:0] r_data;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_cyc(input logic drv, input logic val, output logic line_s, output logic oe_s);
        @(negedge clk);
        host_en  = drv;
        host_val = val;
        repeat (4) @(negedge clk);
        mdc = 1'b1;
        repeat (2) @(negedge clk);
        line_s = mdio_line;
        oe_s   = mdio_oe;
        if (mdio_oe) r_any_oe = 1'b1;
        repeat (2) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd);
        logic l, o;
        r_any_oe = 1'b0;
        bit_cyc(1'b1, 1'b0, l, o);
        for (int i = 0; i < pre; i++) bit_cyc(1'b1, 1'b1, l, o);
        bit_cyc(1'b1, 1'b0, l, o);
        bit_cyc(1'b1, 1'b1, l, o);
        for (int i = 1; i >= 0; i--) bit_cyc(1'b1, op[i], l, o);
        for (int i = 4; i >= 0; i--) bit_cyc(1'b1, phy[i], l, o);
        for (int i = 4; i >= 0; i--) bit_cyc(1'b1, rg[i], l, o);
        if (op == 2'b10) begin
            bit_cyc(1'b0, 1'b1, l, o); r_ta1_oe = o;
            bit_cyc(1'b0, 1'b1, l, o); r_ta2_line = l; r_ta2_oe = o;
            for (int i = 15; i >= 0; i--) begin
                bit_cyc(1'b0, 1'b1, l, o);
                r_data[i] = l;
            end
        end else begin
            bit_cyc(1'b1, 1'b1, l, o);
            bit_cyc(1'b1, 1'b0, l, o);
            for (int i = 15; i >= 0; i--) bit_cyc(1'b1, wd[i], l, o);
        end
        bit_cyc(1'b0, 1'b1, l, o); r_quiet_oe = o;
        bit_cyc(1'b0, 1'b1, l, o); r_slot_line = l;
        repeat (2) @(negedge clk);
        r_rel_oe = mdio_oe;
    endtask

    function automatic logic [15:0] model_read(input int p, input logic [4:0] rg);
        case (rg)
            5'd0:    return m_ctl[p];
            5'd1:    return {15'b0, m_pend[p]};
            5'd2:    return {15'b0, m_en[p]};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic model_slot();
        logic s = 1'b0;
        for (int i = 0; i < 4; i++) s = s | (m_pend[i] & m_en[i]);
        return s;
    endfunction

    task automatic pulse_irq(input logic [3:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = 4'b0;
        for (int i = 0; i < 4; i++) if (m[i]) m_pend[i] = 1'b1;
    endtask

    // run one frame and check it against the model; tag names the ignore reason
    task automatic do_frame(input string tag, input int pre, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        logic        hit;
        int          p;
        logic [15:0] exp_rd;
        logic        exp_slot;
        hit = (pre >= 32) && (op == 2'b10 || op == 2'b01) && (phy[4:2] == devsel);
        p = int'(phy[1:0]);
        exp_rd = model_read(p, rg);
        frame(pre, op, phy, rg, wd);
        if (hit && op == 2'b10 && rg == 5'd1) m_pend[p] = 1'b0;
        if (hit && op == 2'b01 && rg == 5'd0) m_ctl[p] = wd;
        if (hit && op == 2'b01 && rg == 5'd2) m_en[p] = wd[0];
        exp_slot = model_slot();
        if (hit) begin
            if (op == 2'b10) begin
                chk("R5 turnaround bit1 undriven", r_ta1_oe, 0);
                chk("R5 turnaround bit2 driven low", {r_ta2_oe, r_ta2_line}, 2'b10);
                if (rg == 5'd1 || rg == 5'd2 || rg > 5'd2)
                    chk("R10 read data", r_data, exp_rd);
                else
                    chk("R5 read data", r_data, exp_rd);
            end
            chk("R7 quiet bit undriven", r_quiet_oe, 0);
            if (exp_slot) chk("R8 interrupt slot low", r_slot_line, 0);
            else          chk("R9 interrupt slot idle", r_slot_line, 1);
            chk("R8 released after fall", r_rel_oe, 0);
        end else begin
            chk(tag, r_any_oe, 0);
        end
        chk("R4 control words", ctl_regs, {m_ctl[3], m_ctl[2], m_ctl[1], m_ctl[0]});
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ctl[i] = 16'h0; m_en[i] = 1'b0; m_pend[i] = 1'b0;
        end
        void'($urandom(32'h1d2c3b4a));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 oe at reset", mdio_oe, 0);
        chk("R1 control at reset", ctl_regs, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        do_frame("R1", 32, 2'b10, {devsel, 2'd3}, 5'd1, 16'h0);
        do_frame("R1", 32, 2'b10, {devsel, 2'd3}, 5'd2, 16'h0);

        // R4 / R2: distinct data per port
        do_frame("R4", 32, 2'b01, {devsel, 2'd0}, 5'd0, 16'hA5C3);
        do_frame("R2", 32, 2'b01, {devsel, 2'd1}, 5'd0, 16'h1234);
        do_frame("R2", 32, 2'b01, {devsel, 2'd2}, 5'd0, 16'hFFFF);
        do_frame("R2", 32, 2'b01, {devsel, 2'd3}, 5'd0, 16'h0001);
        chk("R2 port1 word", ctl_regs[31:16], 16'h1234);

        // R5 read back, R10 unused address
        do_frame("R5", 32, 2'b10, {devsel, 2'd1}, 5'd0, 16'h0);
        do_frame("R5", 32, 2'b10, {devsel, 2'd0}, 5'd0, 16'h0);
        do_frame("R10", 32, 2'b10, {devsel, 2'd3}, 5'd5, 16'h0);
        do_frame("R10", 32, 2'b01, {devsel, 2'd3}, 5'd7, 16'hBEEF);

        // R6 foreign device select
        do_frame("R6 foreign write undriven", 32, 2'b01, {3'b010, 2'd0}, 5'd0, 16'hDEAD);
        do_frame("R6 foreign read undriven", 40, 2'b10, {3'b100, 2'd2}, 5'd0, 16'h0);

        // R3 preamble length boundary
        do_frame("R3 short preamble undriven", 31, 2'b01, {devsel, 2'd0}, 5'd0, 16'h0000);
        do_frame("R3", 32, 2'b01, {devsel, 2'd0}, 5'd0, 16'h5A5A);

        // R11 invalid opcodes
        do_frame("R11 opcode 11 undriven", 32, 2'b11, {devsel, 2'd1}, 5'd0, 16'h0000);
        do_frame("R11 opcode 00 undriven", 32, 2'b00, {devsel, 2'd1}, 5'd0, 16'h0000);

        // R9 pending but disabled, R8 enabled, R10 clear on read
        pulse_irq(4'b0100);
        do_frame("R9", 32, 2'b10, {devsel, 2'd0}, 5'd0, 16'h0);
        do_frame("R8", 32, 2'b01, {devsel, 2'd2}, 5'd2, 16'h0001);
        do_frame("R8", 32, 2'b10, {devsel, 2'd1}, 5'd0, 16'h0);
        do_frame("R10", 32, 2'b10, {devsel, 2'd2}, 5'd1, 16'h0);
        do_frame("R10", 32, 2'b10, {devsel, 2'd2}, 5'd1, 16'h0);

        // seeded random mix
        for (int n = 0; n < 40; n++) begin
            logic [1:0]  op;
            logic [4:0]  phy;
            logic [4:0]  rg;
            logic [15:0] wd;
            logic [2:0]  ds;
            if ($urandom_range(0, 2) == 0) pulse_irq(4'($urandom_range(0, 15)));
            op = ($urandom_range(0, 1) == 0) ? 2'b10 : 2'b01;
            ds = ($urandom_range(0, 7) == 0) ? (devsel ^ 3'($urandom_range(1, 7))) : devsel;
            phy = {ds, 2'($urandom_range(0, 3))};
            rg = 5'($urandom_range(0, 3));
            wd = 16'($urandom);
            do_frame("R6", 32 + int'($urandom_range(0, 3)), op, phy, rg, wd);
        end

        finish_run();
    end
endmodule